// File: doc/BRIEF.md
# Working Register File with Pointer Pairs

This block holds the thirty-two 8-bit working registers of a small 8-bit CPU core. The execute stage reads two operands at once through combinational read ports and writes one byte result per clock. An instruction that carries an immediate operand supplies only a 4-bit register selector. The block widens that selector so that it reaches only the upper sixteen registers.

The six highest registers form three 16-bit address pointers, named X, Y and Z here. These pointers are always visible as outputs. The address unit can rewrite a whole pointer in one clock through a 16-bit write port. The register file is also mapped into the bottom 32 bytes of the data address space. A load/store unit can therefore read or write any register by its bus address. Any bus address above that window is reported as not belonging to the block and has no effect.

All write sources act on the same rising edge. A fixed priority settles the case where two sources target the same register.

Top module: `cpu_gpr_file`

## Requirements
- R1: While `rst_n` is low, all 32 registers are zero. The clear takes effect at once, without waiting for a clock edge, so the pointer outputs read 0 while reset is held.
- R2: `rd_a_data` and `rd_b_data` show, combinationally, the registers selected by the 5-bit `rd_a_idx` and `rd_b_idx`. Any index 0..31 is valid on both ports in the same cycle.
- R3: When `wr_en` is high, `wr_data` is stored into register `wr_idx` on the rising clock edge. A read of that register in the same cycle still returns the old value.
- R4: When `imm_en` is high, both read port A and the byte write use register 16 + `imm_sel`, and `rd_a_idx` and `wr_idx` are ignored. A selector of 0 reaches register 16 and a selector of 15 reaches register 31. Registers 0..15 cannot be reached in this mode.
- R5: The pointer outputs are built from register pairs. `ptr_x` = {R27, R26}, `ptr_y` = {R29, R28} and `ptr_z` = {R31, R30}, with the even register always holding bits 7:0.
- R6: When `ptr_we` is high, `ptr_wdata` is written to one pair in a single edge. The pair is chosen by `ptr_sel`: 0 selects X, 1 selects Y, 2 selects Z, and 3 writes nothing.
- R7: If the pointer write and the byte write target the same register, the pointer write wins. A byte write to a register outside the written pair still takes effect in the same cycle.
- R8: With `ds_req` high and `ds_addr` in 0x0000..0x001F, `ds_rdata` shows register `ds_addr`. With `ds_we` also high, `ds_wdata` is stored into that register. Otherwise `ds_rdata` is 0.
- R9: A data-space write loses to both the pointer write and the byte write when they target the same register in the same cycle.
- R10: With `ds_req` high and `ds_addr` at 0x0020 or above, `ds_foreign` is 1, `ds_rdata` is 0 and a write changes no register. `ds_foreign` is 0 whenever `ds_req` is low or the address is inside the window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_idx | input | 5 | Read port A register index |
| rd_a_data | output | 8 | Read port A data |
| rd_b_idx | input | 5 | Read port B register index |
| rd_b_data | output | 8 | Read port B data |
| imm_en | input | 1 | Immediate-form selector in use |
| imm_sel | input | 4 | Immediate-form register selector |
| wr_en | input | 1 | Byte write enable |
| wr_idx | input | 5 | Byte write register index |
| wr_data | input | 8 | Byte write data |
| ptr_we | input | 1 | Pointer write enable |
| ptr_sel | input | 2 | Pointer pair select (0 X, 1 Y, 2 Z, 3 none) |
| ptr_wdata | input | 16 | Pointer write data |
| ptr_x | output | 16 | X pointer view |
| ptr_y | output | 16 | Y pointer view |
| ptr_z | output | 16 | Z pointer view |
| ds_req | input | 1 | Data-space access request |
| ds_we | input | 1 | Data-space write |
| ds_addr | input | 16 | Data-space byte address |
| ds_wdata | input | 8 | Data-space write data |
| ds_rdata | output | 8 | Data-space read data |
| ds_foreign | output | 1 | Address is outside the register window |

## Verification
The hardest case to reach from the ports is a single edge on which all three write sources strike the same register. This requires a pointer write to Z, a byte write to register 30 and a bus write to address 0x1E together. Random stimulus seldom lines these up, so a directed cycle drives them at once. The bench then checks that the pointer value survives. It follows this with paired byte/bus and pointer/byte collisions on separate registers, which show that the loser is dropped and that the non-colliding write still lands. Bus addresses whose low five bits alias live registers (0x0020, 0x0120, 0xFFFF) are written and then read back through a read port, which confirms that nothing changed.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  typedef enum logic [1:0] {
    PAIR_X   = 2'd0,
    PAIR_Y   = 2'd1,
    PAIR_Z   = 2'd2,
    PAIR_OFF = 2'd3
  } pair_sel_e;

  localparam int unsigned PAIR_COUNT = 3;
endpackage

// File: rtl/rf_idx_decode.sv
// Selects the effective read-A and write index; immediate selectors land
// in the upper half of the file.
module rf_idx_decode #(
  parameter int unsigned IDX_W = 5
) (
  input  logic             imm_en,
  input  logic [IDX_W-2:0] imm_sel,
  input  logic [IDX_W-1:0] rd_a_idx,
  input  logic [IDX_W-1:0] wr_idx,
  output logic [IDX_W-1:0] eff_rd_a,
  output logic [IDX_W-1:0] eff_wr
);
  localparam int unsigned      HALF_I   = 1 << (IDX_W - 1);
  localparam logic [IDX_W-1:0] IMM_BASE = HALF_I[IDX_W-1:0];

  logic [IDX_W-1:0] imm_idx;

  always_comb begin
    imm_idx  = IMM_BASE + {1'b0, imm_sel};
    eff_rd_a = imm_en ? imm_idx : rd_a_idx;
    eff_wr   = imm_en ? imm_idx : wr_idx;
  end
endmodule

// File: rtl/rf_ds_decode.sv
// Decides whether a data-space address falls in the register window.
module rf_ds_decode #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned IDX_W  = 5
) (
  input  logic              ds_req,
  input  logic [ADDR_W-1:0] ds_addr,
  output logic              ds_hit,
  output logic              ds_foreign,
  output logic [IDX_W-1:0]  ds_idx
);
  logic in_win;

  always_comb begin
    in_win     = (ds_addr[ADDR_W-1:IDX_W] == '0);
    ds_hit     = ds_req & in_win;
    ds_foreign = ds_req & ~in_win;
    ds_idx     = ds_addr[IDX_W-1:0];
  end
endmodule

// File: rtl/rf_write_arb.sv
// Per-register write select: pointer pair first, then byte port, then bus.
module rf_write_arb
  import gpr_pkg::*;
#(
  parameter int unsigned N_REGS   = 32,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned IDX_W    = 5,
  parameter int unsigned PTR_BASE = 26
) (
  input  logic                           bw_en,
  input  logic [IDX_W-1:0]               bw_idx,
  input  logic [DATA_W-1:0]              bw_data,
  input  logic                           pw_en,
  input  logic [1:0]                     pw_sel,
  input  logic [2*DATA_W-1:0]            pw_data,
  input  logic                           dw_en,
  input  logic [IDX_W-1:0]               dw_idx,
  input  logic [DATA_W-1:0]              dw_data,
  output logic [N_REGS-1:0]              reg_we,
  output logic [N_REGS-1:0][DATA_W-1:0]  reg_wd
);
  localparam logic [IDX_W-1:0] PTR_BASE_V = PTR_BASE[IDX_W-1:0];

  logic             pw_active;
  logic [IDX_W-1:0] pw_lo;

  always_comb begin
    pw_active = pw_en && (pair_sel_e'(pw_sel) != PAIR_OFF);
    pw_lo     = PTR_BASE_V + {{(IDX_W-3){1'b0}}, pw_sel, 1'b0};
  end

  for (genvar g = 0; g < N_REGS; g++) begin : g_reg
    localparam logic [IDX_W-1:0] G_IDX = IDX_W'(g);
    logic              we_g;
    logic [DATA_W-1:0] wd_g;

    always_comb begin
      we_g = 1'b0;
      wd_g = bw_data;
      if (pw_active && (pw_lo[IDX_W-1:1] == G_IDX[IDX_W-1:1])) begin
        we_g = 1'b1;
        wd_g = G_IDX[0] ? pw_data[2*DATA_W-1:DATA_W] : pw_data[DATA_W-1:0];
      end else if (bw_en && (bw_idx == G_IDX)) begin
        we_g = 1'b1;
        wd_g = bw_data;
      end else if (dw_en && (dw_idx == G_IDX)) begin
        we_g = 1'b1;
        wd_g = dw_data;
      end
    end

    assign reg_we[g] = we_g;
    assign reg_wd[g] = wd_g;
  end
endmodule

// File: rtl/cpu_gpr_file.sv
module cpu_gpr_file
  import gpr_pkg::*;
#(
  parameter int unsigned N_REGS = 32,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 16,
  localparam int unsigned IDX_W = $clog2(N_REGS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [IDX_W-1:0]    rd_a_idx,
  output logic [DATA_W-1:0]   rd_a_data,
  input  logic [IDX_W-1:0]    rd_b_idx,
  output logic [DATA_W-1:0]   rd_b_data,
  input  logic                imm_en,
  input  logic [IDX_W-2:0]    imm_sel,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                ptr_we,
  input  logic [1:0]          ptr_sel,
  input  logic [2*DATA_W-1:0] ptr_wdata,
  output logic [2*DATA_W-1:0] ptr_x,
  output logic [2*DATA_W-1:0] ptr_y,
  output logic [2*DATA_W-1:0] ptr_z,
  input  logic                ds_req,
  input  logic                ds_we,
  input  logic [ADDR_W-1:0]   ds_addr,
  input  logic [DATA_W-1:0]   ds_wdata,
  output logic [DATA_W-1:0]   ds_rdata,
  output logic                ds_foreign
);
  localparam int unsigned PTR_BASE = N_REGS - 2 * PAIR_COUNT;

  logic [N_REGS-1:0][DATA_W-1:0] rf_q;
  logic [N_REGS-1:0][DATA_W-1:0] rf_d;
  logic [N_REGS-1:0]             reg_we;
  logic [N_REGS-1:0][DATA_W-1:0] reg_wd;
  logic [IDX_W-1:0]              eff_rd_a;
  logic [IDX_W-1:0]              eff_wr;
  logic                          ds_hit;
  logic [IDX_W-1:0]              ds_idx;
  logic [2*DATA_W-1:0]           ptr_view [PAIR_COUNT];

  rf_idx_decode #(.IDX_W(IDX_W)) u_idx (
    .imm_en   (imm_en),
    .imm_sel  (imm_sel),
    .rd_a_idx (rd_a_idx),
    .wr_idx   (wr_idx),
    .eff_rd_a (eff_rd_a),
    .eff_wr   (eff_wr)
  );

  rf_ds_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_ds (
    .ds_req     (ds_req),
    .ds_addr    (ds_addr),
    .ds_hit     (ds_hit),
    .ds_foreign (ds_foreign),
    .ds_idx     (ds_idx)
  );

  rf_write_arb #(
    .N_REGS   (N_REGS),
    .DATA_W   (DATA_W),
    .IDX_W    (IDX_W),
    .PTR_BASE (PTR_BASE)
  ) u_arb (
    .bw_en   (wr_en),
    .bw_idx  (eff_wr),
    .bw_data (wr_data),
    .pw_en   (ptr_we),
    .pw_sel  (ptr_sel),
    .pw_data (ptr_wdata),
    .dw_en   (ds_hit & ds_we),
    .dw_idx  (ds_idx),
    .dw_data (ds_wdata),
    .reg_we  (reg_we),
    .reg_wd  (reg_wd)
  );

  // next state: per-register clock enable
  always_comb begin
    for (int i = 0; i < N_REGS; i++) begin
      rf_d[i] = reg_we[i] ? reg_wd[i] : rf_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rf_q <= '0;
    end else begin
      rf_q <= rf_d;
    end
  end

  always_comb begin
    rd_a_data = rf_q[eff_rd_a];
    rd_b_data = rf_q[rd_b_idx];
    ds_rdata  = ds_hit ? rf_q[ds_idx] : '0;
  end

  for (genvar p = 0; p < PAIR_COUNT; p++) begin : g_ptr
    assign ptr_view[p] = {rf_q[PTR_BASE + 2*p + 1], rf_q[PTR_BASE + 2*p]};
  end

  assign ptr_x = ptr_view[0];
  assign ptr_y = ptr_view[1];
  assign ptr_z = ptr_view[2];
endmodule

// File: rtl/gpr_file_chk.sv
module gpr_file_chk #(
  parameter int unsigned N_REGS = 32,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 16,
  localparam int unsigned IDX_W = $clog2(N_REGS)
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       imm_en,
  input logic                       wr_en,
  input logic [IDX_W-1:0]           wr_idx,
  input logic [DATA_W-1:0]          wr_data,
  input logic                       ptr_we,
  input logic [1:0]                 ptr_sel,
  input logic [2*DATA_W-1:0]        ptr_wdata,
  input logic [2*DATA_W-1:0]        ptr_x,
  input logic [2*DATA_W-1:0]        ptr_y,
  input logic [2*DATA_W-1:0]        ptr_z,
  input logic                       ds_req,
  input logic                       ds_we,
  input logic [ADDR_W-1:0]          ds_addr,
  input logic [N_REGS*DATA_W-1:0]   rf_flat
);
  localparam int unsigned LOW_BITS = (N_REGS / 2) * DATA_W;

  logic              q_v;
  logic [IDX_W-1:0]  q_idx;
  logic [DATA_W-1:0] q_dat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_v   <= 1'b0;
      q_idx <= '0;
      q_dat <= '0;
    end else begin
      q_v   <= wr_en && !imm_en && !ptr_we;
      q_idx <= wr_idx;
      q_dat <= wr_data;
    end
  end

  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (rf_flat == '0));

  a_r3_byte_write: assert property (@(posedge clk) disable iff (!rst_n)
    q_v |-> (rf_flat[q_idx*DATA_W +: DATA_W] == q_dat));

  a_r4_low_half_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (imm_en && !(ds_req && ds_we)) |=> $stable(rf_flat[LOW_BITS-1:0]));

  a_r6_ptr_x_write: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_we && ptr_sel == 2'd0) |=> (ptr_x == $past(ptr_wdata)));

  a_r6_ptr_y_write: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_we && ptr_sel == 2'd1) |=> (ptr_y == $past(ptr_wdata)));

  a_r6_ptr_none: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_we && ptr_sel == 2'd3 && !wr_en && !ds_we) |=> $stable(rf_flat));

  a_r7_ptr_beats_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_we && ptr_sel == 2'd2 && wr_en) |=> (ptr_z == $past(ptr_wdata)));

  a_r10_foreign_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_req && ds_we && (ds_addr >= ADDR_W'(N_REGS)) && !wr_en && !ptr_we)
      |=> $stable(rf_flat));
endmodule

bind cpu_gpr_file gpr_file_chk #(
  .N_REGS (N_REGS),
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .imm_en    (imm_en),
  .wr_en     (wr_en),
  .wr_idx    (wr_idx),
  .wr_data   (wr_data),
  .ptr_we    (ptr_we),
  .ptr_sel   (ptr_sel),
  .ptr_wdata (ptr_wdata),
  .ptr_x     (ptr_x),
  .ptr_y     (ptr_y),
  .ptr_z     (ptr_z),
  .ds_req    (ds_req),
  .ds_we     (ds_we),
  .ds_addr   (ds_addr),
  .rf_flat   (rf_q)
);

// File: tb/sim_cpu_gpr_file.sv
module sim_cpu_gpr_file;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [4:0]  rd_a_idx, rd_b_idx, wr_idx;
  logic [7:0]  rd_a_data, rd_b_data, wr_data, ds_wdata, ds_rdata;
  logic        imm_en, wr_en, ptr_we, ds_req, ds_we, ds_foreign;
  logic [3:0]  imm_sel;
  logic [1:0]  ptr_sel;
  logic [15:0] ptr_wdata, ptr_x, ptr_y, ptr_z, ds_addr;

  logic [7:0] m [32];
  int n_chk;
  int n_fail;
  bit done;

  cpu_gpr_file u0 (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .imm_en(imm_en), .imm_sel(imm_sel),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .ptr_we(ptr_we), .ptr_sel(ptr_sel), .ptr_wdata(ptr_wdata),
    .ptr_x(ptr_x), .ptr_y(ptr_y), .ptr_z(ptr_z),
    .ds_req(ds_req), .ds_we(ds_we), .ds_addr(ds_addr),
    .ds_wdata(ds_wdata), .ds_rdata(ds_rdata), .ds_foreign(ds_foreign)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  task automatic idle();
    rd_a_idx = '0; rd_b_idx = '0; imm_en = 0; imm_sel = '0;
    wr_en = 0; wr_idx = '0; wr_data = '0;
    ptr_we = 0; ptr_sel = 2'd3; ptr_wdata = '0;
    ds_req = 0; ds_we = 0; ds_addr = '0; ds_wdata = '0;
  endtask

  task automatic model_clear();
    foreach (m[i]) m[i] = 8'h00;
  endtask

  // behavioural update: later statements win, giving the priority order
  task automatic model_edge();
    if (ds_req && ds_we && ds_addr < 16'd32) m[ds_addr[4:0]] = ds_wdata;
    if (wr_en) begin
      if (imm_en) m[16 + int'(imm_sel)] = wr_data;
      else        m[wr_idx] = wr_data;
    end
    if (ptr_we && ptr_sel != 2'd3) begin
      m[26 + 2*int'(ptr_sel)] = ptr_wdata[7:0];
      m[27 + 2*int'(ptr_sel)] = ptr_wdata[15:8];
    end
  endtask

  task automatic compare_now();
    int  ai;
    bit  inw;
    ai  = imm_en ? 16 + int'(imm_sel) : int'(rd_a_idx);
    inw = (ds_addr < 16'd32);
    chk(imm_en ? "R4" : "R2", {8'h00, rd_a_data}, {8'h00, m[ai]});
    chk("R2", {8'h00, rd_b_data}, {8'h00, m[rd_b_idx]});
    chk("R5", ptr_x, {m[27], m[26]});
    chk("R5", ptr_y, {m[29], m[28]});
    chk("R5", ptr_z, {m[31], m[30]});
    chk("R8", {8'h00, ds_rdata}, (ds_req && inw) ? {8'h00, m[ds_addr[4:0]]} : 16'h0000);
    chk("R10", {15'd0, ds_foreign}, {15'd0, ds_req && !inw});
  endtask

  // called just after a falling edge with inputs set; returns after the next one
  task automatic cycle();
    #1 compare_now();  // R3: pending write must not show yet
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic peek(string tag, int idx, logic [7:0] exp);
    idle();
    rd_b_idx = 5'(idx);
    #1 chk(tag, {8'h00, rd_b_data}, {8'h00, exp});
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 0;
    rst_n = 1'b0;
    idle();
    model_clear();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: every register reads zero after reset
    for (int i = 0; i < 32; i++) peek("R1", i, 8'h00);

    // R3: fill every register, reading it in the same cycle
    for (int i = 0; i < 32; i++) begin
      idle();
      wr_en = 1; wr_idx = 5'(i); wr_data = 8'(i * 37 + 5); rd_a_idx = 5'(i);
      cycle();
    end
    for (int i = 0; i < 32; i++) peek("R3", i, 8'(i * 37 + 5));

    // R8: bus reads across the whole window
    for (int i = 0; i < 32; i++) begin
      idle();
      ds_req = 1; ds_addr = 16'(i);
      #1 chk("R8", {8'h00, ds_rdata}, {8'h00, 8'(i * 37 + 5)});
      @(negedge clk);
    end

    // R4: immediate selector ends of range, raw write index ignored
    idle(); imm_en = 1; imm_sel = 4'd0;  wr_en = 1; wr_idx = 5'd0; wr_data = 8'hA5; cycle();
    idle(); imm_en = 1; imm_sel = 4'd15; wr_en = 1; wr_idx = 5'd1; wr_data = 8'h5A; cycle();
    peek("R4", 16, 8'hA5);
    peek("R4", 31, 8'h5A);
    peek("R4", 0, 8'h05);
    peek("R4", 1, 8'h2A);

    // R6: whole-pair writes, selector 3 does nothing
    idle(); ptr_we = 1; ptr_sel = 2'd0; ptr_wdata = 16'h1234; cycle();
    idle(); ptr_we = 1; ptr_sel = 2'd1; ptr_wdata = 16'h5678; cycle();
    idle(); ptr_we = 1; ptr_sel = 2'd2; ptr_wdata = 16'h9ABC; cycle();
    idle(); ptr_we = 1; ptr_sel = 2'd3; ptr_wdata = 16'hFFFF; cycle();
    #1;
    chk("R6", ptr_x, 16'h1234);
    chk("R6", ptr_y, 16'h5678);
    chk("R6", ptr_z, 16'h9ABC);
    @(negedge clk);
    peek("R6", 26, 8'h34);
    peek("R6", 27, 8'h12);

    // R7 and R9: three writers on register 30 in one edge
    idle();
    ptr_we = 1; ptr_sel = 2'd2; ptr_wdata = 16'hBEEF;
    wr_en = 1; wr_idx = 5'd30; wr_data = 8'h11;
    ds_req = 1; ds_we = 1; ds_addr = 16'h001E; ds_wdata = 8'h22;
    cycle();
    #1 chk("R7", ptr_z, 16'hBEEF);
    @(negedge clk);
    // R9: byte write beats bus write
    idle(); wr_en = 1; wr_idx = 5'd5; wr_data = 8'h33;
    ds_req = 1; ds_we = 1; ds_addr = 16'h0005; ds_wdata = 8'h44;
    cycle();
    peek("R9", 5, 8'h33);
    // R9: pointer beats bus write on register 28
    idle(); ptr_we = 1; ptr_sel = 2'd1; ptr_wdata = 16'hC0DE;
    ds_req = 1; ds_we = 1; ds_addr = 16'h001C; ds_wdata = 8'h99;
    cycle();
    peek("R9", 28, 8'hDE);
    // R7: byte write outside the pair still lands
    idle(); ptr_we = 1; ptr_sel = 2'd0; ptr_wdata = 16'h0F0F;
    wr_en = 1; wr_idx = 5'd3; wr_data = 8'h77;
    cycle();
    peek("R7", 3, 8'h77);
    #1 chk("R7", ptr_x, 16'h0F0F);
    @(negedge clk);
    // R8: plain bus write
    idle(); ds_req = 1; ds_we = 1; ds_addr = 16'h0007; ds_wdata = 8'hC3; cycle();
    peek("R8", 7, 8'hC3);

    // R10: addresses aliasing live registers change nothing
    idle(); ds_req = 1; ds_we = 1; ds_addr = 16'h0020; ds_wdata = 8'hEE; cycle();
    idle(); ds_req = 1; ds_we = 1; ds_addr = 16'h0120; ds_wdata = 8'hEE; cycle();
    idle(); ds_req = 1; ds_we = 1; ds_addr = 16'hFFFF; ds_wdata = 8'hEE; cycle();
    peek("R10", 0, 8'h05);
    peek("R10", 31, m[31]);
    idle(); ds_req = 0; ds_addr = 16'h4000;
    #1 chk("R10", {15'd0, ds_foreign}, 16'd0);
    @(negedge clk);

    // R1: asynchronous clear in mid-run
    idle();
    #2 rst_n = 1'b0;
    #1;
    chk("R1", ptr_x, 16'h0000);
    chk("R1", ptr_z, 16'h0000);
    model_clear();
    @(negedge clk);
    rst_n = 1'b1;
    peek("R1", 3, 8'h00);

    // mixed traffic against the model
    for (int k = 0; k < 3000; k++) begin
      idle();
      rd_a_idx  = 5'($urandom);
      rd_b_idx  = 5'($urandom);
      imm_en    = ($urandom % 4) == 0;
      imm_sel   = 4'($urandom);
      wr_en     = ($urandom % 2) == 0;
      wr_idx    = 5'($urandom);
      wr_data   = 8'($urandom);
      ptr_we    = ($urandom % 4) == 0;
      ptr_sel   = 2'($urandom);
      ptr_wdata = 16'($urandom);
      ds_req    = ($urandom % 2) == 0;
      ds_we     = ($urandom % 2) == 0;
      ds_addr   = (($urandom % 4) != 0) ? 16'($urandom % 32) : 16'($urandom);
      ds_wdata  = 8'($urandom);
      cycle();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule